// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits beside one processor core and decides, without asking the memory system, whether a store-exclusive may go out. A load-exclusive records the granule-aligned address it touched and arms a reservation. A later store-exclusive goes out only if the reservation is still armed and the store falls in the same granule. A store that fails the check is held back inside the core, and the block reports a status of 0. A swap skips the check entirely. A clear-exclusive request drops the reservation.

Each failed store-exclusive advances a count of consecutive failures. A successful store-exclusive sets that count back to zero. A one-cycle warning is raised on every `WARN_PERIOD`-th consecutive failure. Software or debug logic can use this warning to spot a core stuck in a retry loop. The default period is 100000.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive (`req_kind` = 2'd0) arms the reservation and records `req_addr` with its low `GRAN_LOG2` bits cleared. A later load-exclusive replaces the recorded granule even if the reservation is already armed.
- R2: A store-exclusive (`req_kind` = 2'd1) is accepted when the reservation is armed and its aligned address equals the recorded granule. It then gives `store_permit`=1 and `status_ok`=1 with `status_valid`=1, and the reservation is disarmed.
- R3: A store-exclusive is rejected when the reservation is not armed. It then gives `store_permit`=0, `status_valid`=1 and `status_ok`=0.
- R4: A store-exclusive whose aligned address differs from the recorded granule is rejected in the same way as R3, and it disarms the reservation.
- R5: A swap (`req_kind` = 2'd2) always gives `store_permit`=1 and `status_ok`=1. It leaves the reservation and the failure count unchanged.
- R6: A clear-exclusive (`req_kind` = 2'd3) disarms the reservation.
- R7: `livelock_warn` pulses together with the status of the failure that brings the consecutive-failure count to a nonzero multiple of `WARN_PERIOD`. A successful store-exclusive sets the count back to zero.
- R8: Synchronous reset disarms the reservation, clears the recorded granule and zeroes the failure count. All outputs are 0 during reset.
- R9: All outputs are registered and appear exactly one cycle after the request. Loads, clears and idle cycles produce no `store_permit`, `status_valid` or `livelock_warn`.
- R10: Two addresses that differ only in their low `GRAN_LOG2` bits fall in the same granule and are treated as matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Physical address of the request |
| req_kind | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 swap, 3 clear-exclusive |
| store_permit | output | 1 | Store may proceed to memory |
| status_valid | output | 1 | Status result present |
| status_ok | output | 1 | Status value: 1 success, 0 failure |
| livelock_warn | output | 1 | Periodic consecutive-failure warning pulse |

## Verification
Some rules are checked by the bound checker on every clock cycle:
- A permit always comes with a successful status, and a failed status never comes with a permit.
- A status appears only in the cycle after a store-exclusive or a swap.
- A warning never appears without a failure beside it.
- A store-exclusive that directly follows a clear-exclusive always fails.

Other behaviour depends on state built up over sequences of requests, so only the bench's directed scenarios can show it. This covers granule matching and overwriting, disarm-on-failure, swaps leaving the reservation and count untouched, and the exact position of warnings across counter resets.

// File: rtl/excl_pkg.sv
package excl_pkg;

  typedef enum logic [1:0] {
    KIND_LDEX = 2'd0,
    KIND_STEX = 2'd1,
    KIND_SWAP = 2'd2,
    KIND_CLRX = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic permit;
    logic valid;
    logic ok;
    logic warn;
  } resp_t;

endpackage

// File: rtl/excl_lock_reg.sv
module excl_lock_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_en,
  input  logic              disarm_en,
  input  logic [ADDR_W-1:0] granule_in,
  output logic              armed,
  output logic [ADDR_W-1:0] granule_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      granule_q <= '0;
    end else if (arm_en) begin
      armed     <= 1'b1;
      granule_q <= granule_in;
    end else if (disarm_en) begin
      armed     <= 1'b0;
    end
  end

endmodule

// File: rtl/excl_check.sv
module excl_check
  import excl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              req_valid,
  input  req_kind_e         kind,
  input  logic              armed,
  input  logic [ADDR_W-1:0] granule_q,
  input  logic [ADDR_W-1:0] granule_req,
  output logic              do_arm,
  output logic              do_disarm,
  output logic              stex_pass,
  output logic              stex_fail,
  output logic              swap_go
);

  logic is_stex;
  logic same_granule;

  always_comb begin
    is_stex      = req_valid && (kind == KIND_STEX);
    same_granule = (granule_q == granule_req);
    stex_pass    = is_stex && armed && same_granule;
    stex_fail    = is_stex && !(armed && same_granule);
    swap_go      = req_valid && (kind == KIND_SWAP);
    do_arm       = req_valid && (kind == KIND_LDEX);
    do_disarm    = is_stex || (req_valid && (kind == KIND_CLRX));
  end

endmodule

// File: rtl/excl_fail_tracker.sv
module excl_fail_tracker #(
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_ev,
  input  logic pass_ev,
  output logic warn_ev
);

  generate
    if (WARN_PERIOD <= 1) begin : g_every
      assign warn_ev = fail_ev;
    end else begin : g_phase
      localparam int PH_W = $clog2(WARN_PERIOD);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(WARN_PERIOD - 1);
      logic [PH_W-1:0] phase_q;
      logic            at_last;

      assign at_last = (phase_q == PH_LAST);
      assign warn_ev = fail_ev && at_last;

      always_ff @(posedge clk) begin
        if (rst || pass_ev) begin
          phase_q <= '0;
        end else if (fail_ev) begin
          phase_q <= at_last ? '0 : phase_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRAN_LOG2   = 4,
  parameter int WARN_PERIOD = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              store_permit,
  output logic              status_valid,
  output logic              status_ok,
  output logic              livelock_warn
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_LOG2) - ADDR_W'(1));

  req_kind_e         kind;
  logic [ADDR_W-1:0] granule_req;
  logic [ADDR_W-1:0] granule_q;
  logic              armed;
  logic              do_arm, do_disarm, stex_pass, stex_fail, swap_go, warn_ev;
  resp_t             resp_d, resp_q;

  assign kind        = req_kind_e'(req_kind);
  assign granule_req = req_addr & GRAN_MASK;

  excl_check #(.ADDR_W(ADDR_W)) u_check (
    .req_valid   (req_valid),
    .kind        (kind),
    .armed       (armed),
    .granule_q   (granule_q),
    .granule_req (granule_req),
    .do_arm      (do_arm),
    .do_disarm   (do_disarm),
    .stex_pass   (stex_pass),
    .stex_fail   (stex_fail),
    .swap_go     (swap_go)
  );

  excl_lock_reg #(.ADDR_W(ADDR_W)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .arm_en     (do_arm),
    .disarm_en  (do_disarm),
    .granule_in (granule_req),
    .armed      (armed),
    .granule_q  (granule_q)
  );

  excl_fail_tracker #(.WARN_PERIOD(WARN_PERIOD)) u_track (
    .clk     (clk),
    .rst     (rst),
    .fail_ev (stex_fail),
    .pass_ev (stex_pass),
    .warn_ev (warn_ev)
  );

  always_comb begin
    resp_d.permit = stex_pass || swap_go;
    resp_d.valid  = stex_pass || swap_go || stex_fail;
    resp_d.ok     = stex_pass || swap_go;
    resp_d.warn   = warn_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) resp_q <= '0;
    else     resp_q <= resp_d;
  end

  assign store_permit  = resp_q.permit;
  assign status_valid  = resp_q.valid;
  assign status_ok     = resp_q.ok;
  assign livelock_warn = resp_q.warn;

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_kind,
  input logic              store_permit,
  input logic              status_valid,
  input logic              status_ok,
  input logic              livelock_warn
);

  // R2 / R5: a permit carries a successful status
  a_r2_permit_ok: assert property (@(posedge clk) disable iff (rst)
    store_permit |-> (status_valid && status_ok));

  // R3 / R4: a failed status never carries a permit
  a_r3_fail_blocks: assert property (@(posedge clk) disable iff (rst)
    (status_valid && !status_ok) |-> !store_permit);

  // R9: status only one cycle after a store-exclusive or swap
  a_r9_status_source: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_kind == 2'd0 || req_kind == 2'd3)) |=> !status_valid);

  // R6: store-exclusive right after a clear-exclusive fails
  a_r6_clear_then_fail: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd1 && $past(req_valid && req_kind == 2'd3))
      |=> (status_valid && !status_ok));

  // R7: a warning comes only with a failure
  a_r7_warn_on_fail: assert property (@(posedge clk) disable iff (rst)
    livelock_warn |-> (status_valid && !status_ok));

  // R8: outputs quiet in the cycle after a reset cycle
  a_r8_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !(store_permit || status_valid || livelock_warn));

  logic unused_addr;
  assign unused_addr = ^req_addr;

endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_addr      (req_addr),
  .req_kind      (req_kind),
  .store_permit  (store_permit),
  .status_valid  (status_valid),
  .status_ok     (status_ok),
  .livelock_warn (livelock_warn)
);

// File: tb/excl_monitor_test.sv
module excl_monitor_test;

  localparam int AW = 32;
  localparam int WP = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_kind;
  logic          store_permit, status_valid, status_ok, livelock_warn;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .GRAN_LOG2(4), .WARN_PERIOD(WP)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .store_permit(store_permit), .status_valid(status_valid),
    .status_ok(status_ok), .livelock_warn(livelock_warn)
  );

  task automatic check(input string tag, input logic ep, input logic ev,
                       input logic eo, input logic ew);
    checks++;
    if ({store_permit, status_valid, status_ok, livelock_warn} !== {ep, ev, eo, ew}) begin
      failures++;
      $display("FAIL %s: permit/valid/ok/warn actual=%b%b%b%b expected=%b%b%b%b",
               tag, store_permit, status_valid, status_ok, livelock_warn, ep, ev, eo, ew);
    end
  endtask

  // drive at negedge, outputs registered at the next posedge, sample at next negedge
  task automatic req(input logic [1:0] k, input logic [AW-1:0] a);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_addr = '0;
    repeat (3) @(negedge clk);
    check("R8 outputs in reset", 0, 0, 0, 0);
    rst = 1'b0;
    idle();
    req(2'd1, 32'h0);
    check("R8 flag clear after reset", 0, 1, 0, 0);
  endtask

  task automatic t_pass();
    req(2'd0, 32'h1000);
    check("R9 load gives no status", 0, 0, 0, 0);
    req(2'd1, 32'h1000);
    check("R2 matching store passes", 1, 1, 1, 0);
    idle();
    check("R9 single-cycle output", 0, 0, 0, 0);
    req(2'd1, 32'h1000);
    check("R2 success disarms", 0, 1, 0, 0);
  endtask

  task automatic t_granule();
    req(2'd0, 32'h2003);
    req(2'd1, 32'h200C);
    check("R10 same granule, other low bits", 1, 1, 1, 0);
    req(2'd0, 32'h200F);
    req(2'd1, 32'h2010);
    check("R4 next granule mismatches", 0, 1, 0, 0);
    req(2'd1, 32'h200F);
    check("R4 mismatch disarms", 0, 1, 0, 0);
  endtask

  task automatic t_overwrite();
    req(2'd0, 32'h3000);
    req(2'd0, 32'h4000);
    req(2'd1, 32'h3000);
    check("R1 old granule replaced", 0, 1, 0, 0);
    req(2'd0, 32'h3000);
    req(2'd0, 32'h4000);
    req(2'd1, 32'h4000);
    check("R1 new granule recorded", 1, 1, 1, 0);
  endtask

  task automatic t_clear();
    req(2'd0, 32'h5000);
    req(2'd3, 32'h0);
    check("R9 clear gives no status", 0, 0, 0, 0);
    req(2'd1, 32'h5000);
    check("R6 clear disarms", 0, 1, 0, 0);
    req(2'd1, 32'h5000);
    check("R3 unarmed store fails", 0, 1, 0, 0);
  endtask

  task automatic t_swap();
    req(2'd2, 32'h9990);
    check("R5 swap unarmed permitted", 1, 1, 1, 0);
    req(2'd0, 32'h6000);
    req(2'd2, 32'h7000);
    check("R5 swap other address permitted", 1, 1, 1, 0);
    req(2'd1, 32'h6000);
    check("R5 swap left reservation", 1, 1, 1, 0);
  endtask

  task automatic t_warn();
    req(2'd0, 32'h8000);
    req(2'd1, 32'h8000);
    check("R7 success resets count", 1, 1, 1, 0);
    for (int i = 1; i <= 12; i++) begin
      req(2'd1, 32'h8000);
      check($sformatf("R7 failure %0d", i), 0, 1, 0, (i % WP) == 0);
      if (i == 3) begin
        req(2'd2, 32'h8000);
        check("R5 swap amid failures", 1, 1, 1, 0);
      end
    end
    req(2'd0, 32'h8000);
    req(2'd1, 32'h8000);
    check("R7 success again", 1, 1, 1, 0);
    for (int i = 1; i <= WP; i++) begin
      req(2'd1, 32'h8000);
      check($sformatf("R7 after reset count, failure %0d", i), 0, 1, 0, i == WP);
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_granule();
    t_overwrite();
    t_clear();
    t_swap();
    t_warn();
    idle();
    check("R9 idle quiet", 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule